// File: doc/BRIEF.md
# Peak-Current-Mode Gate Pulse Controller

This block is the clocked logic core of a peak-current-mode switching regulator controller. A counter stands in for the timing ramp of an analog oscillator. Each oscillator period is split into a charge phase and a discharge phase, and their lengths in clocks come from two input buses. A gate pulse opens at the start of each period. It closes when the charge phase runs out or when a current-limit trip is seen, whichever happens first. A trip sets a latch. That latch holds the gate low for the rest of the period, so each period carries at most one pulse.

A build-time parameter chooses between two variants. In the full-rate variant the gate is forced low for the whole discharge phase. In the half-rate variant a toggle stage lets only every other period produce a pulse. This variant does not blank during discharge, so an untripped pulse lasts exactly one oscillator period and the duty ceiling is exactly half.

Two supply monitors with hysteresis, one for the main supply and one for the regulated rail, hold the gate low and restart the oscillator while their supply is not good. An over-temperature flag freezes the oscillator but leaves the trip latch working. The trip input is asynchronous and is synchronized inside the block. Leading-edge blanking ignores trips for a programmable number of clocks after each pulse starts. All pins are plain control and status lines with no handshake, so no back-pressure applies anywhere.

Top module: `pwm_gate_core`

## Requirements
- R1: An oscillator period lasts charge_len clocks of charge followed by discharge_len clocks of discharge, where a length of 0 acts as 1. A new period starts when the discharge phase ends.
- R2: In the full-rate variant (HALF_RATE=0) with no trip, gate_out is high for exactly the charge phase of each period and low for the whole discharge phase.
- R3: trip_in passes through a two-flop synchronizer and then sets the trip latch, which ends the pulse. The gate stays low until the next period start even after trip_in returns low. A one-clock trip pulse driven just before clock edge k ends the pulse after edge k+2.
- R4: During the first blank_len clocks after a pulse starts, trips are ignored. With trip_in held high and blank_len+1 < charge_len, each full-rate pulse lasts blank_len+1 clocks.
- R5: In the half-rate variant (HALF_RATE=1) with no trip, gate_out is high for one whole oscillator period and low for the next, giving exactly 50% duty.
- R6: The main supply monitor compares vmain_code, an unsigned code with one fractional bit, against an upper and a lower threshold. It turns good at or above the upper threshold and turns not-good below the lower one. With MAIN_LOW_OPT=0 the thresholds are codes 32 and 20 (16.0 and 10.0). With MAIN_LOW_OPT=1 they are 17 and 15. Between the thresholds the previous state holds.
- R7: The rail monitor works the same way on vrail_code, with default thresholds 9 (on) and 8 (off). While either supply is not good, gate_out is low, the latch is set and the oscillator is held at the start of charge.
- R8: While overtemp is high, the oscillator stands still and a pulse already in progress continues. A trip still ends that pulse, and the gate then stays low until overtemp clears. After overtemp clears, periods resume.
- R9: After reset the toggle stage is cleared, the trip latch is set and the oscillator begins at the start of charge. As a result, gate_out is low for the whole first period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| charge_len | input | CNT_W | Charge phase length in clocks |
| discharge_len | input | CNT_W | Discharge phase length in clocks |
| blank_len | input | BLK_W | Leading-edge blanking length in clocks |
| trip_in | input | 1 | Asynchronous current-limit trip |
| vmain_code | input | SUP_W | Main supply level code, one fractional bit |
| vrail_code | input | SUP_W | Regulated rail level code, one fractional bit |
| overtemp | input | 1 | Over-temperature flag |
| gate_out | output | 1 | Gate drive pulse |

## Verification
The period-start edge that clears the trip latch and a trip that is ready to be honoured can fall on the same clock. The clear must win, and the trip must then count only once blanking has expired. This case is provoked by holding trip_in high across many period boundaries with random phase and blanking lengths. It is judged by requiring every pulse to be exactly blank_len+1 clocks wide. A trip that arrives while over-temperature is active is a second meeting point. It is judged by a pulse that outlasts its charge phase and then ends on the trip.

// File: rtl/pwm_gate_pkg.sv
package pwm_gate_pkg;
  typedef enum logic {
    PH_CHG = 1'b0,
    PH_DIS = 1'b1
  } osc_phase_e;
endpackage

// File: rtl/pwm_sync2.sv
module pwm_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta   <= 1'b0;
      q_sync <= 1'b0;
    end else begin
      meta   <= d_async;
      q_sync <= meta;
    end
  end
endmodule

// File: rtl/pwm_supply_mon.sv
module pwm_supply_mon #(
  parameter int SUP_W = 6,
  parameter logic [SUP_W-1:0] ON_CODE  = SUP_W'(32),
  parameter logic [SUP_W-1:0] OFF_CODE = SUP_W'(20)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SUP_W-1:0] level,
  output logic             good
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) good <= 1'b0;
    else if (good) good <= (level >= OFF_CODE);
    else good <= (level >= ON_CODE);
  end
endmodule

// File: rtl/pwm_osc.sv
module pwm_osc
  import pwm_gate_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             freeze,
  input  logic [CNT_W-1:0] chg_len,
  input  logic [CNT_W-1:0] dis_len,
  output logic             in_chg,
  output logic             cyc_start,
  output logic [CNT_W-1:0] cnt
);
  osc_phase_e      ph;
  logic [CNT_W-1:0] last_c, last_d;
  logic             phase_end;

  assign last_c    = (chg_len == '0) ? '0 : chg_len - 1'b1;
  assign last_d    = (dis_len == '0) ? '0 : dis_len - 1'b1;
  assign phase_end = (ph == PH_CHG) ? (cnt >= last_c) : (cnt >= last_d);
  assign in_chg    = (ph == PH_CHG);
  assign cyc_start = !restart && !freeze && (ph == PH_DIS) && phase_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph  <= PH_CHG;
      cnt <= '0;
    end else if (restart) begin
      ph  <= PH_CHG;
      cnt <= '0;
    end else if (!freeze) begin
      if (phase_end) begin
        ph  <= (ph == PH_CHG) ? PH_DIS : PH_CHG;
        cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwm_gate_core.sv
module pwm_gate_core #(
  parameter int CNT_W        = 8,
  parameter int BLK_W        = 6,
  parameter int SUP_W        = 6,
  parameter bit HALF_RATE    = 1'b0,
  parameter bit MAIN_LOW_OPT = 1'b0,
  parameter logic [SUP_W-1:0] RAIL_ON  = SUP_W'(9),
  parameter logic [SUP_W-1:0] RAIL_OFF = SUP_W'(8)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] charge_len,
  input  logic [CNT_W-1:0] discharge_len,
  input  logic [BLK_W-1:0] blank_len,
  input  logic             trip_in,
  input  logic [SUP_W-1:0] vmain_code,
  input  logic [SUP_W-1:0] vrail_code,
  input  logic             overtemp,
  output logic             gate_out
);
  localparam logic [SUP_W-1:0] MAIN_ON  = MAIN_LOW_OPT ? SUP_W'(17) : SUP_W'(32);
  localparam logic [SUP_W-1:0] MAIN_OFF = MAIN_LOW_OPT ? SUP_W'(15) : SUP_W'(20);

  logic             main_ok, rail_ok, sup_ok;
  logic             trip_s, ot_q, latch;
  logic             in_chg, cyc_start;
  logic [CNT_W-1:0] osc_cnt;
  logic [BLK_W-1:0] blank_cnt;

  pwm_supply_mon #(.SUP_W(SUP_W), .ON_CODE(MAIN_ON), .OFF_CODE(MAIN_OFF)) u_main (
    .clk(clk), .rst_n(rst_n), .level(vmain_code), .good(main_ok));

  pwm_supply_mon #(.SUP_W(SUP_W), .ON_CODE(RAIL_ON), .OFF_CODE(RAIL_OFF)) u_rail (
    .clk(clk), .rst_n(rst_n), .level(vrail_code), .good(rail_ok));

  assign sup_ok = main_ok & rail_ok;

  pwm_sync2 u_trip_sync (.clk(clk), .rst_n(rst_n), .d_async(trip_in), .q_sync(trip_s));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ot_q <= 1'b0;
    else ot_q <= overtemp;
  end

  pwm_osc #(.CNT_W(CNT_W)) u_osc (
    .clk(clk), .rst_n(rst_n), .restart(!sup_ok), .freeze(ot_q),
    .chg_len(charge_len), .dis_len(discharge_len),
    .in_chg(in_chg), .cyc_start(cyc_start), .cnt(osc_cnt));

  // Blanking window reloads at every period start and counts down.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) blank_cnt <= '0;
    else if (!sup_ok) blank_cnt <= '0;
    else if (cyc_start) blank_cnt <= blank_len;
    else if (blank_cnt != '0) blank_cnt <= blank_cnt - 1'b1;
  end

  // Trip latch: period start clears it with priority over a trip.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) latch <= 1'b1;
    else if (!sup_ok) latch <= 1'b1;
    else if (cyc_start) latch <= 1'b0;
    else if (trip_s && (blank_cnt == '0)) latch <= 1'b1;
  end

  generate
    if (HALF_RATE) begin : g_half
      logic tog;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tog <= 1'b0;
        else if (!sup_ok) tog <= 1'b0;
        else if (cyc_start) tog <= ~tog;
      end
      assign gate_out = tog & ~latch & sup_ok;
    end else begin : g_full
      assign gate_out = in_chg & ~latch & sup_ok;
    end
  endgenerate
endmodule

// File: rtl/pwm_gate_chk.sv
module pwm_gate_chk #(
  parameter int CNT_W = 8,
  parameter int BLK_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             gate_out,
  input logic             in_chg,
  input logic             cyc_start,
  input logic             latch,
  input logic             sup_ok,
  input logic             ot_q,
  input logic [CNT_W-1:0] osc_cnt,
  input logic [BLK_W-1:0] blank_cnt
);
  assert_rise_on_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_out) |-> $past(cyc_start));

  assert_blank_masks_trip_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_cnt != '0 && sup_ok) |=> !$rose(latch));

  assert_supply_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !sup_ok |=> (osc_cnt == '0 && in_chg && latch));

  assert_ot_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ot_q && sup_ok) |=> $stable(osc_cnt));

  assert_ot_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ot_q && latch) |=> latch);
endmodule

bind pwm_gate_core pwm_gate_chk #(.CNT_W(CNT_W), .BLK_W(BLK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .gate_out(gate_out), .in_chg(in_chg),
  .cyc_start(cyc_start), .latch(latch), .sup_ok(sup_ok), .ot_q(ot_q),
  .osc_cnt(osc_cnt), .blank_cnt(blank_cnt));

// File: tb/pwm_gate_core_test.sv
module pwm_gate_core_test;
  localparam int CW = 8;
  localparam int BW = 6;
  localparam int SW = 6;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n, trip, ot;
  logic [CW-1:0] chg, dis;
  logic [BW-1:0] blk;
  logic [SW-1:0] vmain, vrail;
  logic          g_full, g_half;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  pwm_gate_core #(.CNT_W(CW), .BLK_W(BW), .SUP_W(SW), .HALF_RATE(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .charge_len(chg), .discharge_len(dis), .blank_len(blk),
    .trip_in(trip), .vmain_code(vmain), .vrail_code(vrail), .overtemp(ot), .gate_out(g_full));

  pwm_gate_core #(.CNT_W(CW), .BLK_W(BW), .SUP_W(SW), .HALF_RATE(1'b1)) uut_h (
    .clk(clk), .rst_n(rst_n), .charge_len(chg), .discharge_len(dis), .blank_len(blk),
    .trip_in(trip), .vmain_code(vmain), .vrail_code(vrail), .overtemp(ot), .gate_out(g_half));

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic gsel(input bit h);
    return h ? g_half : g_full;
  endfunction

  function automatic int eff_len(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  // Wait for the next pulse and return its width in clocks (-1 on timeout).
  task automatic run_high(input bit h, output int w);
    int n = 0;
    w = -1;
    while (gsel(h) !== 1'b0 && n < 3000) begin @(negedge clk); n++; end
    while (gsel(h) !== 1'b1 && n < 3000) begin @(negedge clk); n++; end
    if (n >= 3000) return;
    w = 0;
    while (gsel(h) === 1'b1 && n < 3000) begin w++; @(negedge clk); n++; end
  endtask

  // Count the low run starting at the current sample.
  task automatic low_after(input bit h, output int w);
    w = 0;
    while (gsel(h) === 1'b0 && w < 3000) begin w++; @(negedge clk); end
  endtask

  task automatic count_high(input bit h, input int n, output int hs);
    hs = 0;
    for (int i = 0; i < n; i++) begin
      if (gsel(h) === 1'b1) hs++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(4ns * 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int w, lw, hs, c, d, b;
    void'($urandom(32'd4242));
    rst_n = 1'b0; trip = 1'b0; ot = 1'b0;
    chg = 8'd10; dis = 8'd4; blk = '0;
    vmain = 6'd40; vrail = 6'd10;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R9: first period carries no pulse
    count_high(0, 12, hs); chk("R9 first period full", hs, 0);

    // R2 / R1 full-rate shape
    run_high(0, w); chk("R2 pulse width", w, 10);
    low_after(0, lw); chk("R1 discharge low", lw, 4);
    // R5 half-rate shape
    run_high(1, w); chk("R5 half high", w, 14);
    low_after(1, lw); chk("R5 half low", lw, 14);

    // R1 zero length acts as one
    chg = 8'd0; dis = 8'd3;
    run_high(0, w);
    run_high(0, w); chk("R1 zero charge width", w, 1);
    low_after(0, lw); chk("R1 discharge 3", lw, 3);

    // Random lengths: R2, R1, R5, R4
    for (int it = 0; it < 6; it++) begin
      c = 4 + int'($urandom % 17);
      d = 1 + int'($urandom % 8);
      b = int'($urandom % (c - 1));
      chg = CW'(c); dis = CW'(d); blk = BW'(b); trip = 1'b0;
      run_high(0, w);
      run_high(0, w); chk("R2 random width", w, eff_len(c));
      low_after(0, lw); chk("R1 random discharge", lw, eff_len(d));
      run_high(1, w);
      run_high(1, w); chk("R5 random half high", w, c + d);
      low_after(1, lw); chk("R5 random half low", lw, c + d);
      trip = 1'b1;
      run_high(0, w);
      run_high(0, w); chk("R4 blank width", w, b + 1);
      trip = 1'b0;
    end

    // R3: short trip ends pulse, latch holds after trip drops
    chg = 8'd20; dis = 8'd6; blk = '0;
    run_high(0, w);
    while (g_full !== 1'b1) @(negedge clk);
    repeat (4) @(negedge clk);
    trip = 1'b1;
    @(negedge clk);
    trip = 1'b0;
    w = 5;
    while (g_full === 1'b1 && w < 100) begin w++; @(negedge clk); end
    chk("R3 trip width", w, 7);
    low_after(0, lw); chk("R3 latched low", lw, 26 - 7);

    // R8: overtemp freezes, trip still ends pulse
    chg = 8'd10; dis = 8'd4;
    run_high(0, w);
    while (g_full !== 1'b1) @(negedge clk);
    @(negedge clk);
    ot = 1'b1;
    count_high(0, 30, hs); chk("R8 pulse continues", hs, 30);
    trip = 1'b1; @(negedge clk); trip = 1'b0;
    repeat (5) @(negedge clk);
    count_high(0, 30, hs); chk("R8 latched under overtemp", hs, 0);
    ot = 1'b0;
    run_high(0, w); chk("R8 resume width", w, 10);

    // R6 hysteresis on main supply
    vmain = 6'd25;
    run_high(0, w); chk("R6 between thresholds stays good", w, 10);
    vmain = 6'd19;
    repeat (3) @(negedge clk);
    count_high(0, 40, hs); chk("R6 below off", hs, 0);
    vmain = 6'd25;
    count_high(0, 40, hs); chk("R6 between thresholds stays bad", hs, 0);
    vmain = 6'd32;
    run_high(0, w); chk("R6 at on threshold", w, 10);

    // R7 rail monitor
    vrail = 6'd7;
    repeat (3) @(negedge clk);
    count_high(0, 40, hs); chk("R7 rail bad", hs, 0);
    count_high(1, 20, hs); chk("R7 rail bad half", hs, 0);
    vrail = 6'd9;
    run_high(0, w); chk("R7 rail good", w, 10);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule